// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block runs the processor half of the handshake for an instruction that a coprocessor executes: moving a value to or from the coprocessor, a coprocessor-internal operation, and multi-word loads and stores between memory and the coprocessor. After `start`, the instruction is offered to the coprocessor. The coprocessor answers in the same cycle with one of four responses. These are accept, busy, refuse, or accept-and-want-another-word.

A busy answer costs one idle cycle, and the instruction is then offered again. During that idle cycle the sequencer looks for pending interrupts and may abandon the instruction. A refusal becomes an exception. For loads and stores, the accepted instruction moves words through a request/acknowledge memory port, stepping the byte address by one word each time. Completion is a one-cycle `done` pulse together with a result code on `exc`.

Top module: `cp_handshake_seq`

## Requirements
- R1: After reset, `busy`, `done`, `cp_valid`, `mem_req` and `wb_strobe` are 0 and `exc` is 0. When `start` is sampled while idle, `cp_valid` rises on the next cycle with `cp_phase` = 0 (initial offer). Operation codes on `op`: 0 put, 1 get, 2 exec, 3 load, 4 store.
- R2: A response of 1 (busy) to an offer with phase 0 or 1 is followed by exactly one cycle with `cp_valid` low. The next offer then carries phase 1 (re-offer) or phase 2 (abandon).
- R3: If an interrupt is taken in that idle cycle, the coprocessor sees one cycle of phase 2. No memory transfer happens. `done` then reports the interrupt code: 5 reset, 6 fast interrupt, 7 normal interrupt.
- R4: Interrupt priority is fixed. `pend_rst` wins over `pend_fiq`, which is taken only when `mask_f` is 0. `pend_fiq` wins over `pend_irq`, which is taken only when `mask_i` is 0. Masked interrupts, and interrupts pending when no busy answer occurs, do not change the outcome.
- R5: A response of 2 (refuse) to an offer ends the instruction. `exc` is 1 (undefined instruction) for put/get/exec and 2 (coprocessor abort) for load/store, and `get_data` reads 0.
- R6: In a load or store, data phases carry phase 3. Each response of 3 (more) to a data phase adds one more word, and response 0 ends the run. Word k goes to byte address `base_addr + 4*k`. Loads write memory data to the coprocessor on `cp_wdata`, and stores write `cp_rdata` to memory with `mem_we` = 1.
- R7: A load or store whose address is not word aligned, or a store below `VEC_TOP` (default 32), ends at once with `exc` = 3 (address abort) and no offer.
- R8: A `mem_abort` sampled with any acknowledge does not stop the run. After the final word, `exc` = 4 (data abort); otherwise `exc` = 0.
- R9: An accepted load or store pulses `wb_strobe` for one cycle exactly when bit 21 of `instr` is 1. Other operations never pulse it.
- R10: A get operation, when accepted, returns the `cp_rdata` value presented with the accepting response on `get_data`. `done` is a single-cycle pulse.
- R11: `mem_req` stays high with a stable `mem_addr` until `mem_ack`. `mem_req` and `cp_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction (sampled while idle) |
| op | input | 3 | Operation code (0 put, 1 get, 2 exec, 3 load, 4 store) |
| instr | input | IW | Instruction word passed to the coprocessor |
| base_addr | input | AW | First byte address for load/store |
| put_data | input | DW | Value sent to the coprocessor by a put |
| pend_rst | input | 1 | Reset request pending |
| pend_fiq | input | 1 | Fast interrupt pending |
| pend_irq | input | 1 | Normal interrupt pending |
| mask_f | input | 1 | Fast interrupt mask |
| mask_i | input | 1 | Normal interrupt mask |
| cp_valid | output | 1 | Offer or data phase presented |
| cp_phase | output | 2 | 0 initial, 1 re-offer, 2 abandon, 3 data |
| cp_instr | output | IW | Instruction presented |
| cp_wdata | output | DW | Data to the coprocessor |
| cp_resp | input | 2 | 0 accept/last, 1 busy, 2 refuse, 3 more |
| cp_rdata | input | DW | Data from the coprocessor |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | DW | Memory read data |
| mem_abort | input | 1 | Memory abort, valid with acknowledge |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| exc | output | 3 | Result code (0 none .. 7) |
| get_data | output | DW | Value returned by a get |
| wb_strobe | output | 1 | Base register writeback strobe |

## Verification
The bench sweeps every operation against zero to two busy answers, refusal, word counts of one to three, and both settings of bit 21. It also varies memory latency and the position of a memory abort. A design that dropped the idle cycle, or re-offered with the wrong phase, would break the recorded offer spacing. A design that stopped at the first memory abort would move fewer words than expected. All 32 combinations of pending interrupts and masks are driven with and without a busy answer, so a wrong priority order, or an interrupt taken without a stall, shows up as a wrong code. Boundary addresses on each side of the vector limit, and misaligned ones, check that the address abort fires before any offer.

// File: rtl/cphs_pkg.sv
package cphs_pkg;
  typedef enum logic [2:0] {
    OP_PUT = 3'd0, OP_GET = 3'd1, OP_EXEC = 3'd2, OP_LOAD = 3'd3, OP_STORE = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    PH_FIRST = 2'd0, PH_BUSY = 2'd1, PH_INTR = 2'd2, PH_DATA = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    RS_GO = 2'd0, RS_BUSY = 2'd1, RS_CANT = 2'd2, RS_MORE = 2'd3
  } resp_e;

  typedef enum logic [2:0] {
    EX_NONE = 3'd0, EX_UNDEF = 3'd1, EX_CPABT = 3'd2, EX_ADDR = 3'd3,
    EX_DABT = 3'd4, EX_RST = 3'd5, EX_FIQ = 3'd6, EX_IRQ = 3'd7
  } exc_e;

  typedef enum logic [2:0] {
    S_IDLE, S_OFFER, S_STALL, S_INTR, S_XFER, S_MEM
  } state_e;
endpackage

// File: rtl/cphs_irq_pick.sv
module cphs_irq_pick
  import cphs_pkg::*;
(
  input  logic       pend_rst,
  input  logic       pend_fiq,
  input  logic       pend_irq,
  input  logic       mask_f,
  input  logic       mask_i,
  output logic       take,
  output logic [2:0] code
);
  always_comb begin
    take = 1'b1;
    if (pend_rst)                  code = EX_RST;
    else if (pend_fiq && !mask_f)  code = EX_FIQ;
    else if (pend_irq && !mask_i)  code = EX_IRQ;
    else begin
      take = 1'b0;
      code = EX_NONE;
    end
  end
endmodule

// File: rtl/cphs_addr_unit.sv
module cphs_addr_unit #(
  parameter int AW      = 16,
  parameter int STEP    = 4,
  parameter int VEC_TOP = 32
) (
  input  logic [AW-1:0] addr,
  input  logic          is_store,
  output logic          bad,
  output logic [AW-1:0] next
);
  localparam int ALIGN_BITS = $clog2(STEP);
  localparam logic [AW-1:0] VEC_LIM = AW'(VEC_TOP);

  always_comb begin
    bad  = (|addr[ALIGN_BITS-1:0]) || (is_store && (addr < VEC_LIM));
    next = addr + AW'(STEP);
  end
endmodule

// File: rtl/cp_handshake_seq.sv
module cp_handshake_seq
  import cphs_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int IW      = 32,
  parameter int WB_BIT  = 21,
  parameter int VEC_TOP = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic [IW-1:0] instr,
  input  logic [AW-1:0] base_addr,
  input  logic [DW-1:0] put_data,
  input  logic          pend_rst,
  input  logic          pend_fiq,
  input  logic          pend_irq,
  input  logic          mask_f,
  input  logic          mask_i,
  output logic          cp_valid,
  output logic [1:0]    cp_phase,
  output logic [IW-1:0] cp_instr,
  output logic [DW-1:0] cp_wdata,
  input  logic [1:0]    cp_resp,
  input  logic [DW-1:0] cp_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_abort,
  output logic          busy,
  output logic          done,
  output logic [2:0]    exc,
  output logic [DW-1:0] get_data,
  output logic          wb_strobe
);
  localparam int STEP = DW / 8;

  state_e        state;
  logic [2:0]    op_r;
  logic [AW-1:0] addr_r;
  logic          more_r;
  logic          abt_r;
  logic [2:0]    int_code_r;

  logic          irq_take;
  logic [2:0]    irq_code;
  logic          addr_bad;
  logic [AW-1:0] addr_next;
  logic [AW-1:0] chk_addr;
  logic          chk_store;
  logic          ls_in, ls_r;

  assign ls_in     = (op == OP_LOAD) || (op == OP_STORE);
  assign ls_r      = (op_r == OP_LOAD) || (op_r == OP_STORE);
  assign chk_addr  = (state == S_IDLE) ? base_addr : addr_r;
  assign chk_store = (state == S_IDLE) ? (op == OP_STORE) : (op_r == OP_STORE);
  assign busy      = (state != S_IDLE);

  cphs_irq_pick u_pick (
    .pend_rst (pend_rst), .pend_fiq (pend_fiq), .pend_irq (pend_irq),
    .mask_f   (mask_f),   .mask_i   (mask_i),
    .take     (irq_take), .code     (irq_code)
  );

  cphs_addr_unit #(.AW(AW), .STEP(STEP), .VEC_TOP(VEC_TOP)) u_addr (
    .addr (chk_addr), .is_store (chk_store), .bad (addr_bad), .next (addr_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      op_r       <= OP_PUT;
      addr_r     <= '0;
      more_r     <= 1'b0;
      abt_r      <= 1'b0;
      int_code_r <= EX_NONE;
      cp_valid   <= 1'b0;
      cp_phase   <= PH_FIRST;
      cp_instr   <= '0;
      cp_wdata   <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      done       <= 1'b0;
      exc        <= EX_NONE;
      get_data   <= '0;
      wb_strobe  <= 1'b0;
    end else begin
      done      <= 1'b0;
      wb_strobe <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          op_r   <= op;
          addr_r <= base_addr;
          abt_r  <= 1'b0;
          if (ls_in && addr_bad) begin
            done <= 1'b1;
            exc  <= EX_ADDR;
          end else begin
            exc      <= EX_NONE;
            state    <= S_OFFER;
            cp_valid <= 1'b1;
            cp_phase <= PH_FIRST;
            cp_instr <= instr;
            cp_wdata <= put_data;
          end
        end
        S_OFFER: begin
          cp_valid <= 1'b0;
          case (cp_resp)
            RS_BUSY: state <= S_STALL;
            RS_CANT: begin
              state    <= S_IDLE;
              done     <= 1'b1;
              exc      <= ls_r ? EX_CPABT : EX_UNDEF;
              get_data <= '0;
            end
            default: begin
              if (op_r == OP_GET) get_data <= cp_rdata;
              if (!ls_r) begin
                state <= S_IDLE;
                done  <= 1'b1;
              end else begin
                wb_strobe <= cp_instr[WB_BIT];
                if (op_r == OP_LOAD) begin
                  state    <= S_MEM;
                  mem_req  <= 1'b1;
                  mem_we   <= 1'b0;
                  mem_addr <= addr_r;
                end else begin
                  state    <= S_XFER;
                  cp_valid <= 1'b1;
                  cp_phase <= PH_DATA;
                end
              end
            end
          endcase
        end
        S_STALL: begin
          cp_valid <= 1'b1;
          if (irq_take) begin
            int_code_r <= irq_code;
            cp_phase   <= PH_INTR;
            state      <= S_INTR;
          end else begin
            cp_phase <= PH_BUSY;
            state    <= S_OFFER;
          end
        end
        S_INTR: begin
          cp_valid <= 1'b0;
          state    <= S_IDLE;
          done     <= 1'b1;
          exc      <= int_code_r;
        end
        S_XFER: begin
          cp_valid <= 1'b0;
          more_r   <= (cp_resp == RS_MORE);
          if (op_r == OP_STORE) begin
            state     <= S_MEM;
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_wdata <= cp_rdata;
            mem_addr  <= addr_r;
          end else if (cp_resp == RS_MORE) begin
            state    <= S_MEM;
            addr_r   <= addr_next;
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= addr_next;
          end else begin
            state <= S_IDLE;
            done  <= 1'b1;
            exc   <= abt_r ? EX_DABT : EX_NONE;
          end
        end
        S_MEM: if (mem_ack) begin
          mem_req <= 1'b0;
          abt_r   <= abt_r | mem_abort;
          if (op_r == OP_LOAD) begin
            cp_wdata <= mem_rdata;
            cp_valid <= 1'b1;
            cp_phase <= PH_DATA;
            state    <= S_XFER;
          end else if (more_r) begin
            addr_r   <= addr_next;
            cp_valid <= 1'b1;
            cp_phase <= PH_DATA;
            state    <= S_XFER;
          end else begin
            state <= S_IDLE;
            done  <= 1'b1;
            exc   <= (abt_r | mem_abort) ? EX_DABT : EX_NONE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cphs_chk.sv
module cphs_chk #(
  parameter int AW     = 16,
  parameter int DW     = 32,
  parameter int IW     = 32,
  parameter int WB_BIT = 21
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          cp_valid,
  input logic [1:0]    cp_phase,
  input logic [IW-1:0] cp_instr,
  input logic [1:0]    cp_resp,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack,
  input logic          done,
  input logic [2:0]    exc,
  input logic [DW-1:0] get_data,
  input logic          wb_strobe
);
  // R1
  first_offer_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> ((cp_valid && cp_phase == 2'd0) || (done && exc == 3'd3)));

  // R2
  stall_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (cp_valid && cp_phase <= 2'd1 && cp_resp == 2'd1) |=> !cp_valid);

  // R2
  reoffer_chk: assert property (@(posedge clk) disable iff (rst)
    (cp_valid && cp_phase <= 2'd1 && cp_resp == 2'd1) |=> ##1
      (cp_valid && (cp_phase == 2'd1 || cp_phase == 2'd2)));

  // R3
  intr_end_chk: assert property (@(posedge clk) disable iff (rst)
    (cp_valid && cp_phase == 2'd2) |=> (done && exc >= 3'd5 && !mem_req));

  // R5
  refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (cp_valid && cp_phase <= 2'd1 && cp_resp == 2'd2) |=>
      (done && (exc == 3'd1 || exc == 3'd2) && get_data == '0));

  // R9
  wb_bit_chk: assert property (@(posedge clk) disable iff (rst)
    wb_strobe |-> cp_instr[WB_BIT]);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R11
  port_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && cp_valid));
endmodule

bind cp_handshake_seq cphs_chk #(.AW(AW), .DW(DW), .IW(IW), .WB_BIT(WB_BIT)) u_chk (.*);

// File: tb/sim_cp_handshake_seq.sv
module sim_cp_handshake_seq;
  localparam int AW = 16, DW = 32, IW = 32;

  logic clk = 0, rst = 1;
  logic start = 0;
  logic [2:0] op = 0;
  logic [IW-1:0] instr = 0;
  logic [AW-1:0] base_addr = 0;
  logic [DW-1:0] put_data = 0;
  logic pend_rst = 0, pend_fiq = 0, pend_irq = 0, mask_f = 0, mask_i = 0;
  logic cp_valid; logic [1:0] cp_phase; logic [IW-1:0] cp_instr; logic [DW-1:0] cp_wdata;
  logic [1:0] cp_resp = 1; logic [DW-1:0] cp_rdata = 0;
  logic mem_req, mem_we; logic [AW-1:0] mem_addr; logic [DW-1:0] mem_wdata;
  logic mem_ack = 0, mem_abort = 0; logic [DW-1:0] mem_rdata = 0;
  logic busy, done, wb_strobe; logic [2:0] exc; logic [DW-1:0] get_data;

  cp_handshake_seq u0 (.*);

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  int cyc = 0;
  logic [1:0] scr [0:31];
  int sidx, dph, offers, intr_cnt, wb_cnt, mcount, lat, lat_cnt, abt_idx, ldata_bad, nlog;
  logic [1:0] ph_log [0:15];
  int ph_cyc [0:15];
  logic [AW-1:0] rec_addr [0:7];
  logic rec_we [0:7];
  logic [DW-1:0] rec_wd [0:7];
  logic [AW-1:0] cur_base;
  logic [2:0] cur_op;
  localparam logic [DW-1:0] GETVAL = 32'h600D_1234;
  localparam logic [DW-1:0] SBASE  = 32'hC0DE_0000;

  function automatic logic [DW-1:0] memval(input logic [AW-1:0] a);
    return DW'(a) ^ 32'hA5A5_0000;
  endfunction

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (wb_strobe) wb_cnt++;
    cp_resp = 2'd1;
    if (cp_valid) begin
      if (cp_phase == 2'd3) begin
        if (cur_op == 3'd4) cp_rdata = SBASE + DW'(dph);
        else if (cp_wdata !== memval(cur_base + AW'(4 * dph))) ldata_bad++;
        cp_resp = scr[sidx]; sidx++; dph++;
      end else begin
        if (nlog < 16) begin ph_log[nlog] = cp_phase; ph_cyc[nlog] = cyc; end
        nlog++;
        if (cp_phase == 2'd2) begin intr_cnt++; cp_resp = 2'd0; end
        else begin offers++; cp_rdata = GETVAL; cp_resp = scr[sidx]; sidx++; end
      end
    end
    if (mem_req) begin
      if (lat_cnt >= lat) begin
        mem_ack = 1; mem_abort = (mcount == abt_idx);
        mem_rdata = memval(mem_addr);
        if (mcount < 8) begin rec_addr[mcount] = mem_addr; rec_we[mcount] = mem_we; rec_wd[mcount] = mem_wdata; end
        mcount++; lat_cnt = 0;
      end else begin mem_ack = 0; mem_abort = 0; lat_cnt++; end
    end else begin mem_ack = 0; mem_abort = 0; end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic run_op(input int o, input logic [AW-1:0] a, input bit b21, input int nb,
                        input logic [1:0] first, input int words, input int abt, input int l,
                        input logic [4:0] irqv);
    bit ls, bad, acc;
    int pick, t, e_exc, e_off, e_mem, e_wb;
    ls = (o >= 3);
    for (int i = 0; i < nb; i++) scr[i] = 2'd1;
    scr[nb] = first;
    for (int i = 0; i < words; i++) scr[nb + 1 + i] = (i == words - 1) ? 2'd0 : 2'd3;
    @(negedge clk);
    sidx = 0; dph = 0; offers = 0; intr_cnt = 0; wb_cnt = 0; mcount = 0; lat = l;
    lat_cnt = 0; abt_idx = abt; ldata_bad = 0; nlog = 0; cur_base = a; cur_op = 3'(o);
    {pend_rst, pend_fiq, pend_irq, mask_f, mask_i} = irqv;
    op = 3'(o); base_addr = a; instr = b21 ? 32'h0020_0000 : 32'h0000_0F0F;
    put_data = 32'h1111_2222; start = 1;
    @(negedge clk); start = 0;
    t = 0;
    while (!done && t < 300) begin @(negedge clk); t++; end
    check("R10 done seen", done, 1'b1);
    bad = ls && ((a[1:0] != 0) || (o == 4 && a < 32));
    pick = irqv[4] ? 5 : (irqv[3] && !irqv[1]) ? 6 : (irqv[2] && !irqv[0]) ? 7 : 0;
    acc = 0; e_mem = 0; e_wb = 0;
    if (bad) begin e_exc = 3; e_off = 0; end
    else if (nb > 0 && pick != 0) begin e_exc = pick; e_off = 1; end
    else if (first == 2'd2) begin e_exc = ls ? 2 : 1; e_off = nb + 1; end
    else begin
      acc = 1; e_off = nb + 1;
      e_exc = (ls && abt < words) ? 4 : 0;
      e_mem = ls ? words : 0; e_wb = (ls && b21) ? 1 : 0;
    end
    if (bad) check("R7 address abort code", exc, 64'(e_exc));
    else if (e_exc >= 5) check("R3 R4 interrupt code", exc, 64'(e_exc));
    else if (!acc) check("R5 refuse code", exc, 64'(e_exc));
    else check("R8 final code", exc, 64'(e_exc));
    check("R2 offer count", offers, 64'(e_off));
    check("R3 abandon phase count", intr_cnt, 64'((!bad && nb > 0 && pick != 0) ? 1 : 0));
    if (nlog > 0) check("R1 first phase", ph_log[0], 2'd0);
    for (int i = 1; i < nlog && i < 16; i++) begin
      check("R2 idle gap", ph_cyc[i] - ph_cyc[i-1], 64'd2);
      check("R2 reoffer phase", ph_log[i], (i == nlog - 1 && intr_cnt > 0) ? 2'd2 : 2'd1);
    end
    check("R6 word count", mcount, 64'(e_mem));
    for (int k = 0; k < mcount && k < 8; k++) begin
      check("R6 word address", rec_addr[k], 64'(a + AW'(4 * k)));
      check("R6 write enable", rec_we[k], (o == 4) ? 1'b1 : 1'b0);
      if (o == 4) check("R6 store data", rec_wd[k], SBASE + DW'(k));
    end
    if (o == 3) check("R6 load data to coprocessor", ldata_bad, 0);
    check("R9 writeback pulses", wb_cnt, 64'(e_wb));
    if (!bad && e_exc < 5 && !acc) check("R5 get_data zero", get_data, 0);
    if (acc && o == 1) check("R10 get value", get_data, GETVAL);
    @(negedge clk);
    check("R10 done single pulse", done, 1'b0);
  endtask

  initial begin
    #(20 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 reset busy", busy, 0);
    check("R1 reset done", done, 0);
    check("R1 reset cp_valid", cp_valid, 0);
    check("R1 reset mem_req", mem_req, 0);
    check("R1 reset exc", exc, 0);
    check("R1 reset wb", wb_strobe, 0);
    // R1 R2 R5 R6 R8 R9 R10 sweep over operations
    for (int o = 0; o < 5; o++)
      for (int nb = 0; nb < 3; nb++)
        for (int f = 0; f < 2; f++)
          for (int w = 1; w <= ((o >= 3) ? 3 : 1); w++)
            for (int b = 0; b < ((o >= 3) ? 2 : 1); b++)
              for (int ab = 0; ab < ((o >= 3) ? 2 : 1); ab++)
                run_op(o, (o == 4) ? AW'(16'h0100 + 16 * nb) : 16'h0040, b[0], nb,
                       f ? 2'd2 : 2'd0, w, ab ? ((w > 1) ? 1 : 0) : 99, (nb + w) % 3, 5'b0);
    // R3 R4 all interrupt and mask combinations, with and without a stall
    for (int v = 0; v < 32; v++) begin
      run_op(0, 16'h0, 1'b0, 1, 2'd0, 1, 99, 0, 5'(v));
      run_op(3, 16'h0080, 1'b1, 0, 2'd0, 2, 99, 0, 5'(v));
    end
    // R7 address boundaries
    run_op(3, 16'h0042, 1'b1, 0, 2'd0, 1, 99, 0, 5'b0);
    run_op(4, 16'h0101, 1'b1, 0, 2'd0, 1, 99, 0, 5'b0);
    run_op(4, 16'h001C, 1'b1, 0, 2'd0, 1, 99, 0, 5'b0);
    run_op(4, 16'h0020, 1'b1, 0, 2'd0, 2, 99, 1, 5'b0);
    run_op(3, 16'h0000, 1'b0, 1, 2'd0, 2, 0, 0, 5'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule